// File: doc/BRIEF.md
# Message Doorbell to Interrupt Pulse Frame

This block is a 4 KB register frame on a simple 32-bit register bus. Software or a bus master writes an absolute interrupt number into a doorbell register; if that number falls inside the window of lines this frame owns, the matching output line carries a single-clock pulse toward the interrupt controller. Numbers outside the window are dropped without effect.

The window starts at interrupt number `BASE_IRQ + 32` and spans `NUM_LINES` lines. Both values are elaboration parameters. Illegal combinations stop elaboration with an error. Software learns the window from a read-only type register. A fixed interface-identity word and a block of zero-valued identity slots complete the read map. Any access to an unmapped offset, or at an unsupported size, returns zero, changes nothing and raises a one-cycle error flag.

Top module: `msi_pulse_frame`

## Requirements
- R1: A 32-bit read of offset 0x008 returns the first interrupt number (BASE_IRQ+32) in bits [31:16] and NUM_LINES in bits [15:0], one cycle after the read.
- R2: A doorbell write to offset 0x040 whose data bits [9:0] hold a number N with BASE_IRQ+32 <= N < BASE_IRQ+32+NUM_LINES raises only `irq_pulse[N-(BASE_IRQ+32)]`, for exactly the one cycle after the write.
- R3: A doorbell number below or above the window raises no line and no error.
- R4: Doorbell writes on consecutive cycles each produce their own one-cycle pulse, in the same order.
- R5: `bus_size` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved. Writes at 16-bit or 32-bit size are accepted. Writes at 8-bit or reserved size change nothing and raise `bus_err`.
- R6: A read at any size other than 32-bit returns zero and raises `bus_err`.
- R7: A 32-bit read of offset 0xFCC returns 0x0510_0000: product code 0x51 in bits [31:20], with implementer and revision fields zero.
- R8: 32-bit reads of any word offset from 0xFD0 to 0xFFC return zero without an error.
- R9: A read or write to any other offset (including unaligned ones, a read of the doorbell or a write to a read-only register) returns zero, has no effect and raises `bus_err` for one cycle.
- R10: Read data is registered. It is valid in the cycle after the read and is zero in any cycle that follows a cycle with no read.
- R11: While reset is asserted and right after it is released, `bus_rdata`, `bus_err` and `irq_pulse` are all zero.
- R12: Doorbell data bits [31:10] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_size | input | 2 | Access size code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved) |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle access-error flag, registered |
| irq_pulse | output | NUM_LINES | Interrupt pulse lines, one per window entry |

## Verification
Every result of this block is due exactly one cycle after the strobe that causes it. The read data, the error flag and the pulse lines all come from one register stage. The bench drives each access between clock edges and queues the expected rdata, error and pulse vector for that access. A monitor wakes just after the next rising edge, pops one entry and compares all three outputs together. Idle cycles also push all-zero entries, so a stray or stretched pulse, or read data that stays past its cycle, is caught on the cycle it appears.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int ID_W   = 10;
  localparam int MAX_LINES = 128;
  localparam int ID_LIMIT  = 1020;
  localparam int SPI_OFFSET = 32;

  localparam logic [ADDR_W-1:0] OFF_TYPE     = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_DOORBELL = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_IFID     = 12'hFCC;
  localparam logic [ADDR_W-1:0] OFF_ZBLK_LO  = 12'hFD0;
  localparam logic [ADDR_W-1:0] OFF_ZBLK_HI  = 12'hFFC;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam logic [11:0] PRODUCT_CODE = 12'h051;

  function automatic logic [DATA_W-1:0] type_word(input int first_id, input int num_lines);
    return {16'(first_id), 16'(num_lines)};
  endfunction

  function automatic logic [DATA_W-1:0] ifid_word();
    return {PRODUCT_CODE, 20'h0};
  endfunction

  function automatic logic id_in_window(input logic [ID_W-1:0] id, input int first_id,
                                        input int num_lines);
    return (int'(id) >= first_id) && (int'(id) < first_id + num_lines);
  endfunction

endpackage

// File: rtl/msi_access_decode.sv
module msi_access_decode
  import msi_frame_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              rd,
  input  logic              wr,
  output logic              rd_sel_type,
  output logic              rd_sel_ifid,
  output logic              db_fire,
  output logic              acc_err
);
  logic aligned, hit_type, hit_ifid, hit_zblk, hit_db;
  logic rd_mapped, rd_size_ok, wr_size_ok;

  always_comb begin
    aligned    = (addr[1:0] == 2'b00);
    hit_type   = aligned && (addr == OFF_TYPE);
    hit_ifid   = aligned && (addr == OFF_IFID);
    hit_zblk   = aligned && (addr >= OFF_ZBLK_LO) && (addr <= OFF_ZBLK_HI);
    hit_db     = aligned && (addr == OFF_DOORBELL);
    rd_mapped  = hit_type || hit_ifid || hit_zblk;
    rd_size_ok = (size == SZ_WORD);
    wr_size_ok = (size == SZ_WORD) || (size == SZ_HALF);

    rd_sel_type = rd && rd_size_ok && hit_type;
    rd_sel_ifid = rd && rd_size_ok && hit_ifid;
    db_fire     = wr && wr_size_ok && hit_db;
    acc_err     = (rd && !(rd_mapped && rd_size_ok)) ||
                  (wr && !(hit_db && wr_size_ok));
  end
endmodule

// File: rtl/msi_doorbell_fire.sv
module msi_doorbell_fire
  import msi_frame_pkg::*;
#(
  parameter int FIRST_ID  = 32,
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [ID_W-1:0]      id,
  output logic                 in_window,
  output logic [NUM_LINES-1:0] pulse_q
);
  logic [NUM_LINES-1:0] line_hit;

  assign in_window = id_in_window(id, FIRST_ID, NUM_LINES);

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    assign line_hit[k] = fire && (id == ID_W'(FIRST_ID + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q[k] <= 1'b0;
      else        pulse_q[k] <= line_hit[k];
    end
  end
endmodule

// File: rtl/msi_read_port.sv
module msi_read_port
  import msi_frame_pkg::*;
#(
  parameter logic [DATA_W-1:0] TYPE_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_type,
  input  logic              sel_ifid,
  input  logic              err_in,
  output logic [DATA_W-1:0] rdata_q,
  output logic              err_q
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (sel_type)      rdata_d = TYPE_VALUE;
    else if (sel_ifid) rdata_d = ifid_word();
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_in;
    end
  end
endmodule

// File: rtl/msi_pulse_frame.sv
module msi_pulse_frame
  import msi_frame_pkg::*;
#(
  parameter int BASE_IRQ  = 0,
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [11:0]          bus_addr,
  input  logic [1:0]           bus_size,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  output logic [NUM_LINES-1:0] irq_pulse
);
  localparam int FIRST_ID = BASE_IRQ + SPI_OFFSET;
  localparam logic [DATA_W-1:0] TYPE_VALUE = type_word(FIRST_ID, NUM_LINES);

  if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_count
    $error("msi_pulse_frame: NUM_LINES %0d outside 1..%0d", NUM_LINES, MAX_LINES);
  end
  if (BASE_IRQ < 0 || FIRST_ID + NUM_LINES > ID_LIMIT) begin : g_bad_window
    $error("msi_pulse_frame: window %0d+%0d exceeds %0d", FIRST_ID, NUM_LINES, ID_LIMIT);
  end

  logic rd_sel_type, rd_sel_ifid, db_fire, acc_err, db_in_window;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[31:ID_W];

  msi_access_decode u_decode (
    .addr        (bus_addr),
    .size        (bus_size),
    .rd          (bus_rd),
    .wr          (bus_wr),
    .rd_sel_type (rd_sel_type),
    .rd_sel_ifid (rd_sel_ifid),
    .db_fire     (db_fire),
    .acc_err     (acc_err)
  );

  msi_doorbell_fire #(
    .FIRST_ID  (FIRST_ID),
    .NUM_LINES (NUM_LINES)
  ) u_fire (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (db_fire),
    .id        (bus_wdata[ID_W-1:0]),
    .in_window (db_in_window),
    .pulse_q   (irq_pulse)
  );

  msi_read_port #(
    .TYPE_VALUE (TYPE_VALUE)
  ) u_rport (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_type (rd_sel_type),
    .sel_ifid (rd_sel_ifid),
    .err_in   (acc_err),
    .rdata_q  (bus_rdata),
    .err_q    (bus_err)
  );
endmodule

// File: rtl/msi_pulse_frame_chk.sv
module msi_pulse_frame_chk #(
  parameter int FIRST_ID  = 32,
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [11:0]          bus_addr,
  input logic [1:0]           bus_size,
  input logic                 bus_rd,
  input logic [31:0]          bus_rdata,
  input logic                 bus_err,
  input logic [NUM_LINES-1:0] irq_pulse,
  input logic                 db_fire,
  input logic                 db_in_window
);
  // R2: never more than one line at a time
  a_r2_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_pulse));

  // R2: a pulse only follows an accepted in-window doorbell
  a_r2_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |-> $past(db_fire && db_in_window));

  // R4: every accepted in-window doorbell yields a pulse next cycle
  a_r4_each_write_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (db_fire && db_in_window) |=> (|irq_pulse));

  // R3: out-of-window doorbell is silent
  a_r3_outside_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (db_fire && !db_in_window) |=> (irq_pulse == '0) && !bus_err);

  // R6: non-word read gives zero with error
  a_r6_bad_read_size: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_size != 2'd2) |=> (bus_rdata == '0) && bus_err);

  // R1: type register contents
  a_r1_type_value: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_size == 2'd2 && bus_addr == 12'h008) |=>
      (bus_rdata == {16'(FIRST_ID), 16'(NUM_LINES)}));

  // R10: no read, no data
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind msi_pulse_frame msi_pulse_frame_chk #(
  .FIRST_ID  (FIRST_ID),
  .NUM_LINES (NUM_LINES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_size     (bus_size),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .bus_err      (bus_err),
  .irq_pulse    (irq_pulse),
  .db_fire      (db_fire),
  .db_in_window (db_in_window)
);

// File: tb/msi_pulse_frame_tb.sv
`timescale 1ns/1ps
module msi_pulse_frame_tb;
  localparam int BASE  = 8;
  localparam int NL    = 64;
  localparam int FIRST = BASE + 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [1:0]    bus_size = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_err;
  logic [NL-1:0] irq_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0]   rd;
    logic          er;
    logic [NL-1:0] pl;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  msi_pulse_frame #(.BASE_IRQ(BASE), .NUM_LINES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_pulse(irq_pulse));

  function automatic exp_t model(input bit rd, input bit wr, input logic [11:0] a,
                                 input logic [1:0] sz, input logic [31:0] wd, input string tag);
    exp_t e;
    int id;
    e.rd = '0; e.er = 1'b0; e.pl = '0; e.tag = tag;
    if (rd) begin
      if (a[1:0] != 2'b00 || !(a == 12'h008 || a == 12'hFCC || a >= 12'hFD0)) e.er = 1'b1;
      else if (sz != 2'd2) e.er = 1'b1;
      else if (a == 12'h008) e.rd = (32'(FIRST) << 16) + 32'(NL);
      else if (a == 12'hFCC) e.rd = 32'h0510_0000;
    end
    if (wr) begin
      if (a != 12'h040 || !(sz == 2'd1 || sz == 2'd2)) e.er = 1'b1;
      else begin
        id = int'(wd % 1024);
        if (id >= FIRST && id < FIRST + NL) e.pl[id - FIRST] = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic op(input bit rd, input bit wr, input logic [11:0] a,
                    input logic [1:0] sz, input logic [31:0] wd, input string tag);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    sb.push_back(model(rd, wr, a, sz, wd, tag));
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] sz, input string tag);
    op(1'b1, 1'b0, a, sz, 32'h0, tag);
  endtask
  task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] wd, input string tag);
    op(1'b0, 1'b1, a, sz, wd, tag);
  endtask
  task automatic idle(input string tag);
    op(1'b0, 1'b0, 12'h000, 2'd0, 32'h0, tag);
  endtask

  // monitor: one expectation per cycle, sampled just after the edge
  always @(posedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      #1;
      e = sb.pop_front();
      n_cmp++;
      if (bus_rdata !== e.rd || bus_err !== e.er || irq_pulse !== e.pl) begin
        n_bad++;
        $display("FAIL %s: rdata=%h err=%b pulse=%h expected rdata=%h err=%b pulse=%h",
                 e.tag, bus_rdata, bus_err, irq_pulse, e.rd, e.er, e.pl);
      end
    end
  end

  task automatic reset_check(input string tag);
    n_cmp++;
    if (bus_rdata !== '0 || bus_err !== 1'b0 || irq_pulse !== '0) begin
      n_bad++;
      $display("FAIL %s: rdata=%h err=%b pulse=%h expected all zero", tag,
               bus_rdata, bus_err, irq_pulse);
    end
  endtask

  initial begin
    #12;
    reset_check("R11 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check("R11 after release");

    rd(12'h008, 2'd2, "R1 type register");
    rd(12'hFCC, 2'd2, "R7 interface id");
    rd(12'hFD0, 2'd2, "R8 zero block low");
    rd(12'hFE8, 2'd2, "R8 zero block mid");
    rd(12'hFFC, 2'd2, "R8 zero block high");
    rd(12'h008, 2'd1, "R6 half read");
    rd(12'hFCC, 2'd0, "R6 byte read");
    rd(12'h008, 2'd3, "R6 reserved read");
    idle("R10 idle after reads");
    wr(12'h040, 2'd2, 32'd40,   "R2 first line");
    wr(12'h040, 2'd2, 32'd103,  "R2 last line");
    wr(12'h040, 2'd2, 32'd77,   "R2 mid line");
    idle("R2 pulse ends");
    wr(12'h040, 2'd2, 32'd39,   "R3 just below");
    wr(12'h040, 2'd2, 32'd104,  "R3 just above");
    wr(12'h040, 2'd2, 32'd0,    "R3 zero");
    wr(12'h040, 2'd2, 32'd1023, "R3 top id");
    wr(12'h040, 2'd2, 32'd50,   "R4 burst a");
    wr(12'h040, 2'd2, 32'd51,   "R4 burst b");
    wr(12'h040, 2'd2, 32'd52,   "R4 burst c");
    wr(12'h040, 2'd2, 32'd52,   "R4 repeat same line");
    wr(12'h040, 2'd1, 32'd60,   "R5 half write");
    wr(12'h040, 2'd0, 32'd61,   "R5 byte write dropped");
    wr(12'h040, 2'd3, 32'd62,   "R5 reserved write dropped");
    wr(12'h040, 2'd2, 32'hFFFF_FC29, "R12 high bits ignored");
    wr(12'h040, 2'd2, 32'h0000_0428, "R12 bit10 ignored");
    rd(12'h040, 2'd2, "R9 read doorbell");
    wr(12'h008, 2'd2, 32'd45, "R9 write type reg");
    rd(12'h100, 2'd2, "R9 unmapped read");
    rd(12'h009, 2'd2, "R9 unaligned read");
    wr(12'h044, 2'd2, 32'd45, "R9 unmapped write");
    wr(12'h041, 2'd2, 32'd45, "R9 unaligned doorbell");
    rd(12'h008, 2'd2, "R1 type after errors");
    idle("R10 idle zero");
    idle("R10 idle zero 2");
    for (int i = 0; i < 3; i++) @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        #20000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected done");
      end
    join_any
    if (sb.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule